// File: doc/BRIEF.md
# Posted Register Write Synchronizer

This block sits between a fast bus clock domain and a slow functional clock domain, in front of the writable registers of a timer. In posted mode a bus write to one of the synchronized registers completes in the cycle it is presented. The value is held in a bus-side staging register and carried across to the functional domain in the background by a toggle handshake. While a transfer is in flight, the register's own bit in a readable pending register stays set. Software polls that bit before it writes the same register again, because a write that meets a set bit is discarded.

With posted mode off, a write to a synchronized register holds the bus ready signal low until the functional domain has acknowledged the value. The block also has an interface control register with a posted-mode bit and a self-clearing soft-reset bit, and a status register whose bit 0 reports that a soft reset has finished. The functional domain sees each register as a parallel value plus a one-cycle update pulse.

Top module: `posted_wr_sync`

## Requirements
- R1: After hardware reset, interface control (word 0) reads 0x4 (posted mode on), status (word 1) bit 0 reads 1, the pending register (word 2) reads 0, and every functional-domain register copy is 0.
- R2: In posted mode, a write to synchronized register i (word 8+i) gets busReady high in the same cycle, and pending bit i is set from the next cycle. Pending bit positions: 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 to 9 tick registers.
- R3: Once pending bit i clears, functional copy i equals the written value, and funcWrPulse[i] has been high for exactly one functional clock cycle for that transfer.
- R4: A write to register i while pending bit i is set is dropped: the functional copy and the read-back value keep the earlier value.
- R5: A bus read of a synchronized register whose pending bit is set returns all ones, marking invalid data.
- R6: Pending bits of different registers are independent, so several writes to distinct registers can be in flight at once and each arrives intact.
- R7: With posted mode off (interface control bit 2 = 0), a write to a synchronized register keeps busReady low for at least one cycle. When busReady rises, the register's pending bit is 0 and the functional copy already holds the value.
- R8: Writing interface control with bit 1 set starts a soft reset. Until it completes, control bit 1 reads 1 and status bit 0 reads 0. Afterwards control reads 0x4, the pending register reads 0, and every staged value and functional copy is 0.
- R9: Writes to synchronized registers during a soft reset are dropped: they set no pending bit, produce no update pulse, and leave the register at 0.
- R10: Interface control, status and the pending register are not synchronized. Writes to them never set a pending bit, and writes to status and to the pending register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset, bus domain |
| funcClk | input | 1 | Functional clock |
| funcRstN | input | 1 | Asynchronous active-low reset, functional domain |
| busSel | input | 1 | Access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | DATA_W | Write data |
| busReady | output | 1 | Access completes on a clock edge where this is high |
| busRdata | output | DATA_W | Read data, valid while busSel is high |
| funcRegs | output | NUM_POSTED*DATA_W | Functional-domain register copies, register i at bits i*DATA_W and up |
| funcWrPulse | output | NUM_POSTED | One functional-clock pulse per delivered write |

## Verification
The bench writes a register twice back to back and checks that the second value is lost. A design that overwrote a pending transfer would deliver the second value or produce two update pulses. It reads a register while its transfer is in flight and expects the invalid marker; a design that returned the new value early would show ordinary data. In non-posted mode the bench checks that the stall lasts until both the pending bit has cleared and the functional copy has arrived, which catches a ready signal released on acceptance. Around a soft reset it checks the busy indications, the self-clearing control bit, the dropping of a write made during the reset, and that no pending bit is left stale, as happens when the reset ignores in-flight toggles.

// File: rtl/posted_sync_pkg.sv
package posted_sync_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] idx;
    logic             clearAll;
  } stage_ctl_t;
endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/pws_bus_ctrl.sv
module pws_bus_ctrl
  import posted_sync_pkg::*;
#(
  parameter int NUM_POSTED  = 10,
  parameter int ADDR_W      = 5,
  parameter int POSTED_BASE = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [1:0]            ctrlBits,
  input  logic [NUM_POSTED-1:0] ackSync,
  input  logic                  rstAckSync,
  output logic                  busReady,
  output logic [NUM_POSTED-1:0] reqTog,
  output logic                  rstReqTog,
  output logic [NUM_POSTED-1:0] pendVec,
  output logic                  postedMode,
  output logic                  resetBusy,
  output stage_ctl_t            stageCtl
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(POSTED_BASE);
  localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(NUM_POSTED);
  localparam logic [ADDR_W-1:0] CTRL_A  = '0;

  logic [ADDR_W-1:0]     offset;
  logic                  addrIsPosted;
  logic [NUM_POSTED-1:0] hitMask;
  logic                  targetPend;
  logic                  wrReq;
  logic                  launch;
  logic                  waitAck;
  logic                  ctrlWrite;
  logic                  softStart;

  assign offset       = busAddr - BASE_A;
  assign addrIsPosted = (busAddr >= BASE_A) && (offset < COUNT_A);

  for (genvar g = 0; g < NUM_POSTED; g++) begin : gHit
    assign hitMask[g] = addrIsPosted && (offset == ADDR_W'(g));
  end

  assign pendVec    = reqTog ^ ackSync;
  assign resetBusy  = rstReqTog ^ rstAckSync;
  assign targetPend = |(hitMask & pendVec);
  assign wrReq      = busSel && busWrite;
  assign ctrlWrite  = wrReq && (busAddr == CTRL_A) && !resetBusy;
  assign softStart  = ctrlWrite && ctrlBits[0];

  always_comb begin
    launch   = 1'b0;
    busReady = 1'b1;
    if (wrReq && addrIsPosted && !resetBusy) begin
      if (postedMode) begin
        launch = !targetPend;
      end else if (waitAck) begin
        busReady = !targetPend;
      end else begin
        busReady = 1'b0;
        launch   = !targetPend;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqTog     <= '0;
      rstReqTog  <= 1'b0;
      postedMode <= 1'b1;
      waitAck    <= 1'b0;
    end else begin
      reqTog    <= reqTog ^ (hitMask & {NUM_POSTED{launch}});
      rstReqTog <= rstReqTog ^ softStart;
      if (ctrlWrite) postedMode <= softStart ? 1'b1 : ctrlBits[1];
      if (launch && !postedMode) waitAck <= 1'b1;
      else if (busSel && busReady) waitAck <= 1'b0;
    end
  end

  assign stageCtl.load     = launch;
  assign stageCtl.idx      = offset[IDX_W-1:0];
  assign stageCtl.clearAll = softStart;
endmodule

// File: rtl/pws_bus_dp.sv
module pws_bus_dp
  import posted_sync_pkg::*;
#(
  parameter int NUM_POSTED  = 10,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int POSTED_BASE = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  stage_ctl_t                   stageCtl,
  input  logic [DATA_W-1:0]            busWdata,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [NUM_POSTED-1:0]        pendVec,
  input  logic                         postedMode,
  input  logic                         resetBusy,
  output logic [DATA_W-1:0]            busRdata,
  output logic [NUM_POSTED*DATA_W-1:0] stageFlat
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(POSTED_BASE);
  localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(NUM_POSTED);

  logic [DATA_W-1:0] stage [NUM_POSTED];
  logic [ADDR_W-1:0] offset;
  logic              addrIsPosted;

  for (genvar g = 0; g < NUM_POSTED; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= '0;
      else if (stageCtl.clearAll) stage[g] <= '0;
      else if (stageCtl.load && stageCtl.idx == IDX_W'(g)) stage[g] <= busWdata;
    end
    assign stageFlat[g*DATA_W +: DATA_W] = stage[g];
  end

  assign offset       = busAddr - BASE_A;
  assign addrIsPosted = (busAddr >= BASE_A) && (offset < COUNT_A);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(0): busRdata[2:0] = {postedMode, resetBusy, 1'b0};
      ADDR_W'(1): busRdata[0] = !resetBusy;
      ADDR_W'(2): busRdata[NUM_POSTED-1:0] = pendVec;
      default: begin
        for (int i = 0; i < NUM_POSTED; i++) begin
          if (addrIsPosted && offset == ADDR_W'(i))
            busRdata = pendVec[i] ? '1 : stage[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/pws_func_side.sv
module pws_func_side #(
  parameter int NUM_POSTED = 10,
  parameter int DATA_W     = 32
) (
  input  logic                         funcClk,
  input  logic                         funcRstN,
  input  logic [NUM_POSTED-1:0]        reqTog,
  input  logic                         rstReqTog,
  input  logic [NUM_POSTED*DATA_W-1:0] stageFlat,
  output logic [NUM_POSTED*DATA_W-1:0] funcRegs,
  output logic [NUM_POSTED-1:0]        funcWrPulse,
  output logic [NUM_POSTED-1:0]        ackTog,
  output logic                         rstAckTog
);
  logic [NUM_POSTED-1:0] reqSync;
  logic                  rstSync;

  pws_sync #(.WIDTH(NUM_POSTED + 1)) uReqSync (
    .clk (funcClk),
    .rstN(funcRstN),
    .din ({rstReqTog, reqTog}),
    .dout({rstSync, reqSync})
  );

  always_ff @(posedge funcClk or negedge funcRstN) begin
    if (!funcRstN) begin
      funcRegs    <= '0;
      funcWrPulse <= '0;
      ackTog      <= '0;
      rstAckTog   <= 1'b0;
    end else if (rstSync != rstAckTog) begin
      funcRegs    <= '0;
      funcWrPulse <= '0;
      ackTog      <= reqSync;
      rstAckTog   <= rstSync;
    end else begin
      ackTog      <= reqSync;
      funcWrPulse <= reqSync ^ ackTog;
      for (int i = 0; i < NUM_POSTED; i++) begin
        if (reqSync[i] != ackTog[i])
          funcRegs[i*DATA_W +: DATA_W] <= stageFlat[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/posted_wr_sync.sv
module posted_wr_sync
  import posted_sync_pkg::*;
#(
  parameter int NUM_POSTED  = 10,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int POSTED_BASE = 8
) (
  input  logic                         busClk,
  input  logic                         rstN,
  input  logic                         funcClk,
  input  logic                         funcRstN,
  input  logic                         busSel,
  input  logic                         busWrite,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  output logic                         busReady,
  output logic [DATA_W-1:0]            busRdata,
  output logic [NUM_POSTED*DATA_W-1:0] funcRegs,
  output logic [NUM_POSTED-1:0]        funcWrPulse
);
  logic [NUM_POSTED-1:0]        reqTog;
  logic                         rstReqTog;
  logic [NUM_POSTED-1:0]        ackTog;
  logic                         rstAckTog;
  logic [NUM_POSTED-1:0]        ackSync;
  logic                         rstAckSync;
  logic [NUM_POSTED-1:0]        pendVec;
  logic                         postedMode;
  logic                         resetBusy;
  stage_ctl_t                   stageCtl;
  logic [NUM_POSTED*DATA_W-1:0] stageFlat;

  pws_bus_ctrl #(
    .NUM_POSTED(NUM_POSTED), .ADDR_W(ADDR_W), .POSTED_BASE(POSTED_BASE)
  ) uCtrl (
    .clk       (busClk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .ctrlBits  (busWdata[2:1]),
    .ackSync   (ackSync),
    .rstAckSync(rstAckSync),
    .busReady  (busReady),
    .reqTog    (reqTog),
    .rstReqTog (rstReqTog),
    .pendVec   (pendVec),
    .postedMode(postedMode),
    .resetBusy (resetBusy),
    .stageCtl  (stageCtl)
  );

  pws_bus_dp #(
    .NUM_POSTED(NUM_POSTED), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .POSTED_BASE(POSTED_BASE)
  ) uDp (
    .clk       (busClk),
    .rstN      (rstN),
    .stageCtl  (stageCtl),
    .busWdata  (busWdata),
    .busAddr   (busAddr),
    .pendVec   (pendVec),
    .postedMode(postedMode),
    .resetBusy (resetBusy),
    .busRdata  (busRdata),
    .stageFlat (stageFlat)
  );

  pws_func_side #(.NUM_POSTED(NUM_POSTED), .DATA_W(DATA_W)) uFunc (
    .funcClk    (funcClk),
    .funcRstN   (funcRstN),
    .reqTog     (reqTog),
    .rstReqTog  (rstReqTog),
    .stageFlat  (stageFlat),
    .funcRegs   (funcRegs),
    .funcWrPulse(funcWrPulse),
    .ackTog     (ackTog),
    .rstAckTog  (rstAckTog)
  );

  pws_sync #(.WIDTH(NUM_POSTED + 1)) uAckSync (
    .clk (busClk),
    .rstN(rstN),
    .din ({rstAckTog, ackTog}),
    .dout({rstAckSync, ackSync})
  );
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
  parameter int NUM_POSTED  = 10,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int POSTED_BASE = 8
) (
  input logic                         busClk,
  input logic                         rstN,
  input logic                         busSel,
  input logic                         busWrite,
  input logic [ADDR_W-1:0]            busAddr,
  input logic                         busReady,
  input logic [NUM_POSTED-1:0]        pendVec,
  input logic                         postedMode,
  input logic                         resetBusy,
  input logic                         stageLoad,
  input logic [NUM_POSTED*DATA_W-1:0] stageFlat
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(POSTED_BASE);
  localparam logic [ADDR_W-1:0] COUNT_A = ADDR_W'(NUM_POSTED);

  logic [ADDR_W-1:0]     chkOff;
  logic                  chkPosted;
  logic [NUM_POSTED-1:0] chkHit;

  assign chkOff    = busAddr - BASE_A;
  assign chkPosted = (busAddr >= BASE_A) && (chkOff < COUNT_A);
  for (genvar g = 0; g < NUM_POSTED; g++) begin : gChkHit
    assign chkHit[g] = chkPosted && (chkOff == ADDR_W'(g));
  end

  // R2: a launched transfer raises a pending bit on the next edge
  assert_pend_on_launch_R2: assert property (@(posedge busClk) disable iff (!rstN)
    stageLoad |=> ((pendVec & ~$past(pendVec)) != '0));

  // R10: a pending bit only rises after a write to a synchronized address
  assert_pend_cause_R10: assert property (@(posedge busClk) disable iff (!rstN)
    ((pendVec & ~$past(pendVec)) != '0) |-> $past(busSel && busWrite && chkPosted));

  // R4: staged data does not move while its transfer is in flight
  for (genvar g = 0; g < NUM_POSTED; g++) begin : gHold
    assert_stage_hold_R4: assert property (@(posedge busClk) disable iff (!rstN)
      ($past(pendVec[g]) && pendVec[g]) |-> $stable(stageFlat[g*DATA_W +: DATA_W]));
  end

  // R7: non-posted write to a busy register holds the bus
  assert_stall_R7: assert property (@(posedge busClk) disable iff (!rstN)
    (busSel && busWrite && !postedMode && !resetBusy && ((chkHit & pendVec) != '0))
      |-> !busReady);

  // R8: soft reset never completes with a transfer left pending
  assert_reset_clean_R8: assert property (@(posedge busClk) disable iff (!rstN)
    $fell(resetBusy) |-> (pendVec == '0));
endmodule

bind posted_wr_sync pws_checker #(
  .NUM_POSTED(NUM_POSTED), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .POSTED_BASE(POSTED_BASE)
) uChecker (
  .busClk    (busClk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busReady  (busReady),
  .pendVec   (pendVec),
  .postedMode(postedMode),
  .resetBusy (resetBusy),
  .stageLoad (stageCtl.load),
  .stageFlat (stageFlat)
);

// File: tb/tb_posted_wr_sync.sv
module tb_posted_wr_sync;
  localparam int BUS_PERIOD  = 10;
  localparam int FUNC_PERIOD = 34;
  localparam int NP = 10;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int BASE = 8;

  logic busClk = 1'b0;
  logic funcClk = 1'b0;
  logic rstN = 1'b0;
  logic funcRstN = 1'b0;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic busReady;
  logic [DW-1:0] busRdata;
  logic [NP*DW-1:0] funcRegs;
  logic [NP-1:0] funcWrPulse;

  int nChecks = 0;
  int nFail = 0;
  int pulseCnt [NP];

  always #(BUS_PERIOD/2) busClk = ~busClk;
  always #(FUNC_PERIOD/2) funcClk = ~funcClk;

  posted_wr_sync #(.NUM_POSTED(NP), .DATA_W(DW), .ADDR_W(AW), .POSTED_BASE(BASE)) dut (
    .busClk(busClk), .rstN(rstN), .funcClk(funcClk), .funcRstN(funcRstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .funcRegs(funcRegs), .funcWrPulse(funcWrPulse)
  );

  initial for (int i = 0; i < NP; i++) pulseCnt[i] = 0;
  always @(negedge funcClk) begin
    for (int i = 0; i < NP; i++) if (funcWrPulse[i]) pulseCnt[i] = pulseCnt[i] + 1;
  end

  task automatic check(input string tag, input logic [DW-1:0] actual, input logic [DW-1:0] expected);
    nChecks++;
    if (actual !== expected) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
    end
  endtask

  task automatic busWr(input logic [AW-1:0] addr, input logic [DW-1:0] data, output int stalls);
    @(negedge busClk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    stalls = 0;
    #1;
    while (!busReady && stalls < 1000) begin
      @(posedge busClk); #1;
      stalls++;
    end
    @(posedge busClk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [AW-1:0] addr, output logic [DW-1:0] data);
    @(negedge busClk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = addr;
    #1;
    data = busRdata;
    @(posedge busClk); #1;
    busSel = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    logic [DW-1:0] v;
    int n = 0;
    busRd(5'd2, v);
    while (v != 0 && n < 200) begin busRd(5'd2, v); n++; end
    check({tag, " pending drains"}, v, 0);
  endtask

  function automatic logic [DW-1:0] fReg(input int i);
    return funcRegs[i*DW +: DW];
  endfunction

  task automatic t_reset;
    logic [DW-1:0] v;
    busRd(5'd0, v); check("R1 ctrl default", v, 32'h4);
    busRd(5'd1, v); check("R1 status done", v, 32'h1);
    busRd(5'd2, v); check("R1 pending clear", v, 32'h0);
    check("R1 func copies zero", {31'd0, funcRegs == '0}, 32'h1);
  endtask

  task automatic t_posted;
    logic [DW-1:0] v;
    int s;
    busWr(5'(BASE + 1), 32'hA5A5_0001, s);
    check("R2 posted no stall", 32'(s), 0);
    busRd(5'd2, v); check("R2 counter pending bit1", v, 32'h2);
    busRd(5'(BASE + 1), v); check("R5 invalid while pending", v, 32'hFFFF_FFFF);
    waitIdle("R3");
    check("R3 func copy", fReg(1), 32'hA5A5_0001);
    check("R3 one pulse", 32'(pulseCnt[1]), 1);
    busRd(5'(BASE + 1), v); check("R3 readback", v, 32'hA5A5_0001);
  endtask

  task automatic t_drop;
    logic [DW-1:0] v;
    int s;
    busWr(5'(BASE + 4), 32'h11, s);
    busWr(5'(BASE + 4), 32'h22, s);
    waitIdle("R4");
    check("R4 func keeps first", fReg(4), 32'h11);
    busRd(5'(BASE + 4), v); check("R4 readback first", v, 32'h11);
    check("R4 single pulse", 32'(pulseCnt[4]), 1);
  endtask

  task automatic t_multi;
    logic [DW-1:0] v;
    int s;
    busWr(5'(BASE + 0), 32'h100, s);
    busWr(5'(BASE + 9), 32'h900, s);
    busWr(5'(BASE + 3), 32'h300, s);
    busRd(5'd2, v); check("R6 three pending", v, 32'h209);
    waitIdle("R6");
    check("R6 reg0", fReg(0), 32'h100);
    check("R6 reg9", fReg(9), 32'h900);
    check("R6 reg3", fReg(3), 32'h300);
  endtask

  task automatic t_nonposted;
    logic [DW-1:0] v;
    int s;
    busWr(5'd0, 32'h0, s);
    busRd(5'd0, v); check("R7 posted off", v, 32'h0);
    busWr(5'(BASE + 2), 32'hBEEF, s);
    check("R7 stalled", {31'd0, s > 0}, 32'h1);
    check("R7 func copy at ready", fReg(2), 32'hBEEF);
    busRd(5'd2, v); check("R7 nothing pending", v, 32'h0);
    busWr(5'd0, 32'h4, s);
    busRd(5'd0, v); check("R7 posted back on", v, 32'h4);
  endtask

  task automatic t_nonsync;
    logic [DW-1:0] v;
    int s;
    busWr(5'd1, 32'hFFFF_FFFF, s);
    busWr(5'd2, 32'hFFFF_FFFF, s);
    busRd(5'd2, v); check("R10 no pending from plain regs", v, 32'h0);
    busRd(5'd1, v); check("R10 status unchanged", v, 32'h1);
  endtask

  task automatic t_softreset;
    logic [DW-1:0] v;
    int s;
    int n = 0;
    busWr(5'(BASE + 5), 32'h55, s);
    waitIdle("R8 pre");
    busWr(5'd0, 32'h2, s);
    busRd(5'd0, v); check("R8 reset bit visible", v, 32'h6);
    busRd(5'd1, v); check("R8 not done", v, 32'h0);
    busWr(5'(BASE + 6), 32'h66, s);
    busRd(5'd2, v); check("R9 dropped write not pending", v, 32'h0);
    busRd(5'd1, v);
    while (v[0] == 1'b0 && n < 200) begin busRd(5'd1, v); n++; end
    check("R8 done", v, 32'h1);
    busRd(5'd0, v); check("R8 ctrl self-clear", v, 32'h4);
    busRd(5'd2, v); check("R8 pending clear", v, 32'h0);
    busRd(5'(BASE + 5), v); check("R8 staged reg cleared", v, 32'h0);
    repeat (4) @(posedge funcClk);
    check("R8 func copies cleared", {31'd0, funcRegs == '0}, 32'h1);
    busRd(5'(BASE + 6), v); check("R9 reg6 still zero", v, 32'h0);
    check("R9 no pulse", 32'(pulseCnt[6]), 0);
  endtask

  initial begin
    #(BUS_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge funcClk);
    @(negedge busClk);
    rstN = 1'b1; funcRstN = 1'b1;
    repeat (3) @(posedge busClk);
    t_reset();
    t_posted();
    t_drop();
    t_multi();
    t_nonposted();
    t_nonsync();
    t_softreset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule